// File: doc/BRIEF.md
# Attack-Decay Frequency Selector

This block picks a frequency level for one clock domain from a range of `MAX_LVL + 1` settings. Each cycle it adds up the instruction-window occupancy and the number of committed instructions. It then compares each interval's occupancy total with the total from the interval before. What drives the choice is the change in occupancy, not how high it is.

When occupancy jumps by more than a programmable threshold, the level moves by a large step in the direction that counters the jump. This is the attack. When the change is within the threshold, the level drifts down by one per interval. This is the decay. A performance guard watches the decay. If the commit total falls by more than a programmable margin right after a decay step, that step is undone and decay pauses for one interval.

The interval length, the attack threshold and the guard margin are inputs that stay static. All decisions are registered on the last cycle of an interval.

Top module: `attack_decay_fsel`

## Requirements
- R1: Reset sets the level to `RST_LVL`. The first complete interval after reset only records its totals and leaves the level unchanged.
- R2: An interval lasts `intv_len_i` cycles, and a value of 0 acts as 1. The level can change only on the clock edge that ends an interval. It holds in every other cycle.
- R3: If this interval's occupancy sum exceeds the previous sum by more than `atk_thr_i`, the level rises by `ATK_STEP`.
- R4: If this interval's occupancy sum falls below the previous sum by more than `atk_thr_i`, the level drops by `ATK_STEP`.
- R5: If the occupancy change is within `atk_thr_i` in both directions, the level drops by one per interval. This is a decay step.
- R6: Suppose the previous interval ended with a decay step, the change is within threshold, and the commit sum plus `perf_margin_i` is below the previous commit sum. Then the level rises by one, and the next interval is a hold interval.
- R7: In a hold interval with a within-threshold change, the level is unchanged. A hold lasts a single interval.
- R8: The level saturates at 0 and at `MAX_LVL` under attack, decay and undo, and never wraps.
- R9: An attack takes priority over the guard, the hold and the decay, and it cancels any pending hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_i | input | OCC_W | Instruction-window occupancy this cycle |
| cmt_i | input | CMT_W | Instructions committed this cycle |
| intv_len_i | input | INT_W | Interval length in cycles (0 acts as 1) |
| atk_thr_i | input | OCC_W+INT_W | Occupancy-change threshold for an attack |
| perf_margin_i | input | CMT_W+INT_W | Allowed commit drop after a decay step |
| lvl_o | output | LVL_W | Selected frequency level |

## Verification
The bench builds the block with 3-bit occupancy, 2-bit commit counts, 3-bit interval and level widths, seven levels (0 to 6) and an attack step of 2. With these sizes it can sweep every interval length from 0 to 4, thresholds from 0 to 4 and guard margins from 0 to 2. In each setup it drives random, flat and commit-starved traffic, so that every branch, both saturation limits and the undo/hold pair occur many times. An arithmetic model in the bench tracks the sums and the level and checks the output in every cycle.

// File: rtl/attack_decay_fsel.sv
module attack_decay_fsel #(
  parameter int OCC_W    = 6,
  parameter int CMT_W    = 3,
  parameter int INT_W    = 10,
  parameter int LVL_W    = 4,
  parameter int MAX_LVL  = 15,
  parameter int ATK_STEP = 4,
  parameter int RST_LVL  = MAX_LVL
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [OCC_W-1:0]       occ_i,
  input  logic [CMT_W-1:0]       cmt_i,
  input  logic [INT_W-1:0]       intv_len_i,
  input  logic [OCC_W+INT_W-1:0] atk_thr_i,
  input  logic [CMT_W+INT_W-1:0] perf_margin_i,
  output logic [LVL_W-1:0]       lvl_o
);
  localparam int OS_W = OCC_W + INT_W;
  localparam int CS_W = CMT_W + INT_W;
  localparam logic [LVL_W:0] MAX_X = MAX_LVL[LVL_W:0];
  localparam logic [LVL_W:0] ATK_X = ATK_STEP[LVL_W:0];
  localparam logic [LVL_W-1:0] RST_X = RST_LVL[LVL_W-1:0];

  logic [INT_W-1:0] cyc;
  logic [OS_W-1:0]  occ_acc, occ_prev;
  logic [CS_W-1:0]  cmt_acc, cmt_prev;
  logic             have_prev, decayed, hold;
  logic [LVL_W-1:0] lvl;

  logic             last, rise, fall, perf_drop;
  logic [OS_W-1:0]  occ_sum;
  logic [CS_W-1:0]  cmt_sum;
  logic [LVL_W:0]   lvl_x, up_sum;
  logic [LVL_W-1:0] atk_up, atk_dn, nxt_lvl;
  logic             nxt_dec, nxt_hold;

  assign last      = (intv_len_i <= 1) || (cyc >= intv_len_i - 1'b1);
  assign occ_sum   = occ_acc + OS_W'(occ_i);
  assign cmt_sum   = cmt_acc + CS_W'(cmt_i);
  assign rise      = (occ_sum > occ_prev) && (occ_sum - occ_prev > atk_thr_i);
  assign fall      = (occ_prev > occ_sum) && (occ_prev - occ_sum > atk_thr_i);
  assign perf_drop = ({1'b0, cmt_sum} + {1'b0, perf_margin_i}) < {1'b0, cmt_prev};
  assign lvl_x     = {1'b0, lvl};
  assign up_sum    = lvl_x + ATK_X;
  assign atk_up    = (up_sum > MAX_X) ? MAX_X[LVL_W-1:0] : up_sum[LVL_W-1:0];
  assign atk_dn    = (lvl_x >= ATK_X) ? lvl - ATK_X[LVL_W-1:0] : '0;
  assign lvl_o     = lvl;

  always_comb begin
    nxt_lvl  = lvl;
    nxt_dec  = decayed;
    nxt_hold = hold;
    if (have_prev) begin
      nxt_dec  = 1'b0;
      nxt_hold = 1'b0;
      if (rise)
        nxt_lvl = atk_up;
      else if (fall)
        nxt_lvl = atk_dn;
      else if (decayed && perf_drop) begin
        nxt_lvl  = (lvl_x >= MAX_X) ? MAX_X[LVL_W-1:0] : lvl + 1'b1;
        nxt_hold = 1'b1;
      end else if (!hold && lvl != '0) begin
        nxt_lvl = lvl - 1'b1;
        nxt_dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc       <= '0;
      occ_acc   <= '0;
      cmt_acc   <= '0;
      occ_prev  <= '0;
      cmt_prev  <= '0;
      have_prev <= 1'b0;
      decayed   <= 1'b0;
      hold      <= 1'b0;
      lvl       <= RST_X;
    end else if (last) begin
      cyc       <= '0;
      occ_acc   <= '0;
      cmt_acc   <= '0;
      occ_prev  <= occ_sum;
      cmt_prev  <= cmt_sum;
      have_prev <= 1'b1;
      decayed   <= nxt_dec;
      hold      <= nxt_hold;
      lvl       <= nxt_lvl;
    end else begin
      cyc     <= cyc + 1'b1;
      occ_acc <= occ_sum;
      cmt_acc <= cmt_sum;
    end
  end

  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, lvl_o} <= MAX_X);

  p_quiet_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(lvl_o));

  p_attack_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && have_prev && rise) |=> ({1'b0, lvl_o} >= {1'b0, $past(lvl_o)}));

  p_attack_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last && have_prev && fall) |=> ({1'b0, lvl_o} <= {1'b0, $past(lvl_o)}));

  p_small_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !rise && !fall) |=>
      (({1'b0, lvl_o} + 1'b1 >= {1'b0, $past(lvl_o)}) &&
       ({1'b0, lvl_o} <= {1'b0, $past(lvl_o)} + 1'b1)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && hold && !rise && !fall) |=> $stable(lvl_o));

endmodule

// File: tb/attack_decay_fsel_tb.sv
module attack_decay_fsel_tb;
  localparam int OCC_W = 3, CMT_W = 2, INT_W = 3, LVL_W = 3;
  localparam int MAXL = 6, ATK = 2, RSTL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OCC_W-1:0] occ = '0;
  logic [CMT_W-1:0] cmt = '0;
  logic [INT_W-1:0] len = '0;
  logic [OCC_W+INT_W-1:0] thr = '0;
  logic [CMT_W+INT_W-1:0] mrg = '0;
  logic [LVL_W-1:0] lvl;

  always #5 clk = ~clk;

  attack_decay_fsel #(.OCC_W(OCC_W), .CMT_W(CMT_W), .INT_W(INT_W), .LVL_W(LVL_W),
    .MAX_LVL(MAXL), .ATK_STEP(ATK), .RST_LVL(RSTL)) u_dut (
    .clk(clk), .rst_n(rst_n), .occ_i(occ), .cmt_i(cmt), .intv_len_i(len),
    .atk_thr_i(thr), .perf_margin_i(mrg), .lvl_o(lvl));

  int tests = 0, fails = 0, cycles = 0;
  int m_cyc, m_oacc, m_cacc, m_oprev, m_cprev, m_have, m_dec, m_hold, m_lvl;
  string m_tag;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cycles <= cycles + 1;

  function automatic int imin(int a, int b); return a < b ? a : b; endfunction
  function automatic int imax(int a, int b); return a > b ? a : b; endfunction

  task automatic check(int exp, string tag);
    tests++;
    if (int'(lvl) != exp) begin
      fails++;
      $display("FAIL %s: lvl_o=%0d expected %0d at t=%0t", tag, lvl, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cyc = 0; m_oacc = 0; m_cacc = 0; m_oprev = 0; m_cprev = 0;
    m_have = 0; m_dec = 0; m_hold = 0; m_lvl = RSTL; m_tag = "R1";
  endtask

  task automatic model_step(int o, int c);
    int l = int'(len);
    int osum = m_oacc + o, csum = m_cacc + c;
    bit last = (l <= 1) || (m_cyc >= l - 1);
    if (!last) begin
      m_oacc = osum; m_cacc = csum; m_cyc++; m_tag = "R2";
      return;
    end
    if (!m_have) m_tag = "R1";
    else begin
      bit guard = m_dec && (csum + int'(mrg) < m_cprev);
      int nl = m_lvl, nd = 0, nh = 0;
      if (osum - m_oprev > int'(thr)) begin
        nl = imin(m_lvl + ATK, MAXL);
        m_tag = (guard || m_hold) ? "R9" : (m_lvl + ATK > MAXL) ? "R8" : "R3";
      end else if (m_oprev - osum > int'(thr)) begin
        nl = imax(m_lvl - ATK, 0);
        m_tag = (guard || m_hold) ? "R9" : (m_lvl - ATK < 0) ? "R8" : "R4";
      end else if (guard) begin
        nl = imin(m_lvl + 1, MAXL); nh = 1; m_tag = "R6";
      end else if (m_hold) begin
        m_tag = "R7";
      end else if (m_lvl > 0) begin
        nl = m_lvl - 1; nd = 1; m_tag = "R5";
      end else m_tag = "R8";
      m_lvl = nl; m_dec = nd; m_hold = nh;
    end
    m_oprev = osum; m_cprev = csum; m_have = 1;
    m_cyc = 0; m_oacc = 0; m_cacc = 0;
  endtask

  task automatic drive(int seg);
    int o, c;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (seg)
      0: begin o = int'(lfsr[2:0]); c = int'(lfsr[5:4]); end
      1: begin o = 3; c = 3; end
      default: begin o = 4; c = lfsr[7] ? 3 : 0; end
    endcase
    occ = o[OCC_W-1:0]; cmt = c[CMT_W-1:0];
    model_step(o, c);
  endtask

  initial begin
    for (int L = 0; L <= 4; L++)
      for (int T = 0; T <= 4; T++)
        for (int M = 0; M <= 2; M++) begin
          @(negedge clk);
          rst_n = 1'b0;
          len = L[INT_W-1:0]; thr = T[OCC_W+INT_W-1:0]; mrg = M[CMT_W+INT_W-1:0];
          @(negedge clk);
          rst_n = 1'b1;
          model_reset();
          check(RSTL, "R1");
          for (int s = 0; s < 3; s++)
            for (int k = 0; k < 20; k++) begin
              drive(s);
              @(negedge clk);
              check(m_lvl, m_tag);
            end
        end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    fails++;
    $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule